// File: doc/BRIEF.md
# Priority-Masked CLOCK Victim Selector

This block chooses which way of a set-associative set to replace when a new block is installed, and it maintains the per-way reference (recency) bits. It keeps one clock hand per set. On a low-priority insertion it runs a CLOCK sweep starting at that set's hand. The sweep examines one way per cycle, clears the reference bit of each eligible way it passes, and stops at the first eligible way whose reference bit is already clear. High-priority ways are excluded from the sweep for as long as some valid low-priority way is cold, which protects them. Once every low-priority way is referenced, the exclusion is lifted and the sweep covers the whole set, so a cold high-priority way can then be replaced.

A high-priority insertion does not sweep. It replaces the way named on the request, which the surrounding controller derives from a hash of the address. A hit request sets the reference bit of the way that was hit. The caller supplies the valid, priority and reference vectors of the addressed set with each request. It receives the chosen way and the updated reference vector, and it writes them back into its own tag storage. The block accepts one request at a time and reports completion with a single-cycle `done`.

Top module: `clock_victim_sel`

## Requirements
- R1: After a synchronous reset, `ready` is 1, `done` is 0, and every set's hand points at way 0.
- R2: A hit request (`req_hit`=1) completes one cycle after acceptance. It returns `victim_way` = `req_way` and `ref_out` = `req_ref` with bit `req_way` set. The hand is left unchanged.
- R3: A high-priority insertion (`req_hit`=0, `req_high`=1) completes one cycle after acceptance, whatever the valid and reference bits are. It returns `victim_way` = `req_way` and `ref_out` = `req_ref` with that bit set. The hand is left unchanged.
- R4: A low-priority insertion (`req_hit`=0, `req_high`=0) into a set with an invalid way (`req_vld` bit 0) completes one cycle after acceptance. It returns the lowest-numbered invalid way, sets that way's bit in `ref_out`, and leaves the hand unchanged.
- R5: In a fully valid set that holds at least one low-priority way (`req_prio` bit 0) with a clear reference bit, a low-priority insertion never chooses a high-priority way (`req_prio` bit 1) and never changes the reference bit of a high-priority way.
- R6: When every valid low-priority way has its reference bit set, the sweep covers all ways, and a high-priority way can be chosen.
- R7: The sweep visits ways in ascending order with wrap-around, starting at the set's hand. It clears the reference bit of every eligible way it passes and chooses the first eligible way whose reference bit is clear. In `ref_out`, that way's bit is 1.
- R8: After a sweep, the hand of the addressed set moves to the way after the victim, wrapping from the last way to way 0. The hands of other sets do not change.
- R9: A sweep that examines k ways (1 ≤ k ≤ WAYS+1) raises `done` exactly 1+k cycles after acceptance, for one cycle per accepted request.
- R10: `ready` is 0 from acceptance until `done`. A request presented while `ready` is 0 is ignored: it produces no extra `done` and does not alter any hand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_hit | input | 1 | 1: hit update; 0: insertion |
| req_high | input | 1 | For insertions, 1: the incoming block is high priority |
| req_set | input | SETW | Set index, selects the hand |
| req_way | input | IDXW | Hit way, or fixed position of a high-priority insertion |
| req_vld | input | WAYS | Per-way valid bits of the set |
| req_prio | input | WAYS | Per-way priority bits of the set (1 = high) |
| req_ref | input | WAYS | Per-way reference bits of the set |
| ready | output | 1 | Block is idle and can take a request |
| done | output | 1 | One-cycle completion pulse |
| victim_way | output | IDXW | Chosen or updated way, valid with `done` |
| ref_out | output | WAYS | Updated reference vector, valid with `done` |

## Verification
The bench builds the block with 8 ways and 4 sets. With 8 ways, a complete sweep that revisits its starting way (9 examinations) runs in a few cycles. Hand wrap-around from way 7 back to way 0 is reachable with short reference patterns. Four sets let the bench show that one set's hand moves while the other sets' hands stay put. Directed cases then exercise masking, unmasking and busy-time requests, and a seeded run of mixed requests follows them.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sel_state_e;
endpackage

// File: rtl/clock_victim_hand.sv
module clock_victim_hand #(
  parameter int SETS = 64,
  parameter int IDXW = 4,
  localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [SETW-1:0] rd_set,
  output logic [IDXW-1:0] rd_hand,
  input  logic            wr_en,
  input  logic [SETW-1:0] wr_set,
  input  logic [IDXW-1:0] wr_hand
);
  logic [IDXW-1:0] mem [SETS];
  logic [SETS-1:0] touched;
  logic [IDXW-1:0] mem_q;
  logic            touched_q;

  // storage array without reset so that it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_set] <= wr_hand;
    if (rd_en) mem_q <= mem[rd_set];
  end

  // a set never written since reset reads as way 0
  always_ff @(posedge clk) begin
    if (rst) begin
      touched   <= '0;
      touched_q <= 1'b0;
    end else begin
      if (wr_en) touched[wr_set] <= 1'b1;
      if (rd_en) touched_q <= touched[rd_set];
    end
  end

  assign rd_hand = touched_q ? mem_q : '0;
endmodule

// File: rtl/clock_victim_mask.sv
module clock_victim_mask #(
  parameter int WAYS = 16,
  localparam int IDXW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] way_vld,
  input  logic [WAYS-1:0] way_prio,
  input  logic [WAYS-1:0] way_ref,
  output logic [WAYS-1:0] eligible,
  output logic            has_free,
  output logic [IDXW-1:0] free_idx
);
  logic [WAYS-1:0] cold_low;
  logic            any_cold_low;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      assign cold_low[g] = way_vld[g] & ~way_prio[g] & ~way_ref[g];
      assign eligible[g] = ~way_prio[g] | ~any_cold_low;
    end
  endgenerate

  assign any_cold_low = |cold_low;
  assign has_free     = ~&way_vld;

  // lowest-numbered invalid way
  always_comb begin
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_vld[i]) free_idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int WAYS = 16,
  parameter int SETS = 64,
  localparam int IDXW = $clog2(WAYS),
  localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_hit,
  input  logic            req_high,
  input  logic [SETW-1:0] req_set,
  input  logic [IDXW-1:0] req_way,
  input  logic [WAYS-1:0] req_vld,
  input  logic [WAYS-1:0] req_prio,
  input  logic [WAYS-1:0] req_ref,
  output logic            ready,
  output logic            done,
  output logic [IDXW-1:0] victim_way,
  output logic [WAYS-1:0] ref_out
);
  localparam logic [WAYS-1:0] ONE = WAYS'(1);

  sel_state_e      state_q;
  logic [SETW-1:0] set_q;
  logic [WAYS-1:0] ref_w_q;
  logic [WAYS-1:0] elig_q;
  logic [IDXW-1:0] ptr_q;
  logic            first_q;
  logic            done_q;
  logic [IDXW-1:0] victim_q;
  logic [WAYS-1:0] ref_out_q;

  logic [WAYS-1:0] elig;
  logic            has_free;
  logic [IDXW-1:0] free_idx;
  logic [IDXW-1:0] hand_rd;
  logic [IDXW-1:0] cur;
  logic [IDXW-1:0] cur_next;
  logic            accept;
  logic            pick;

  function automatic logic [IDXW-1:0] step(input logic [IDXW-1:0] i);
    return (i == IDXW'(WAYS - 1)) ? '0 : i + 1'b1;
  endfunction

  assign ready    = (state_q == ST_IDLE);
  assign accept   = req_valid & ready;
  assign cur      = first_q ? hand_rd : ptr_q;
  assign cur_next = step(cur);
  assign pick     = (state_q == ST_SWEEP) & elig_q[cur] & ~ref_w_q[cur];

  clock_victim_mask #(.WAYS(WAYS)) i_mask (
    .way_vld  (req_vld),
    .way_prio (req_prio),
    .way_ref  (req_ref),
    .eligible (elig),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  clock_victim_hand #(.SETS(SETS), .IDXW(IDXW)) i_hand (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_set  (req_set),
    .rd_hand (hand_rd),
    .wr_en   (pick),
    .wr_set  (set_q),
    .wr_hand (cur_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      set_q     <= '0;
      ref_w_q   <= '0;
      elig_q    <= '0;
      ptr_q     <= '0;
      first_q   <= 1'b0;
      done_q    <= 1'b0;
      victim_q  <= '0;
      ref_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            set_q <= req_set;
            if (req_hit || req_high) begin
              done_q    <= 1'b1;
              victim_q  <= req_way;
              ref_out_q <= req_ref | (ONE << req_way);
            end else if (has_free) begin
              done_q    <= 1'b1;
              victim_q  <= free_idx;
              ref_out_q <= req_ref | (ONE << free_idx);
            end else begin
              ref_w_q <= req_ref;
              elig_q  <= elig;
              first_q <= 1'b1;
              state_q <= ST_SWEEP;
            end
          end
        end
        ST_SWEEP: begin
          first_q <= 1'b0;
          if (pick) begin
            done_q    <= 1'b1;
            victim_q  <= cur;
            ref_out_q <= ref_w_q | (ONE << cur);
            state_q   <= ST_IDLE;
          end else begin
            if (elig_q[cur]) ref_w_q[cur] <= 1'b0;
            ptr_q <= cur_next;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign victim_way = victim_q;
  assign ref_out    = ref_out_q;
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int WAYS = 16,
  localparam int IDXW = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_hit,
  input logic            req_high,
  input logic [IDXW-1:0] req_way,
  input logic [WAYS-1:0] req_vld,
  input logic [WAYS-1:0] req_prio,
  input logic [WAYS-1:0] req_ref,
  input logic            ready,
  input logic            done,
  input logic [IDXW-1:0] victim_way,
  input logic [WAYS-1:0] ref_out
);
  localparam int CW = $clog2(WAYS + 4) + 1;

  logic            acc;
  logic            cap_lowins;
  logic            cap_cold;
  logic [WAYS-1:0] cap_prio;
  logic [WAYS-1:0] cap_ref;
  logic [CW-1:0]   busy_cnt;

  assign acc = req_valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lowins <= 1'b0;
      cap_cold   <= 1'b0;
      cap_prio   <= '0;
      cap_ref    <= '0;
      busy_cnt   <= '0;
    end else begin
      if (acc) begin
        cap_lowins <= ~req_hit & ~req_high & (&req_vld);
        cap_cold   <= |(req_vld & ~req_prio & ~req_ref);
        cap_prio   <= req_prio;
        cap_ref    <= req_ref;
        busy_cnt   <= CW'(1);
      end else if (!ready && busy_cnt != '1) begin
        busy_cnt <= busy_cnt + 1'b1;
      end
    end
  end

  p_hit_ref_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && req_hit) |=> (done && ref_out == ($past(req_ref) | (WAYS'(1) << $past(req_way)))));

  p_high_pos_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_hit && req_high) |=> (done && victim_way == $past(req_way)));

  p_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (done && cap_lowins && cap_cold) |-> (!cap_prio[victim_way] && ((ref_out ^ cap_ref) & cap_prio) == '0));

  p_victim_ref_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ref_out[victim_way]);

  p_sweep_bound_r9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (busy_cnt <= CW'(WAYS + 1)));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.WAYS(WAYS)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_hit    (req_hit),
  .req_high   (req_high),
  .req_way    (req_way),
  .req_vld    (req_vld),
  .req_prio   (req_prio),
  .req_ref    (req_ref),
  .ready      (ready),
  .done       (done),
  .victim_way (victim_way),
  .ref_out    (ref_out)
);

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;
  localparam int W = 8;
  localparam int S = 4;
  localparam int IW = $clog2(W);
  localparam int SW = $clog2(S);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_hit, req_high;
  logic [SW-1:0] req_set;
  logic [IW-1:0] req_way;
  logic [W-1:0]  req_vld, req_prio, req_ref;
  logic          ready, done;
  logic [IW-1:0] victim_way;
  logic [W-1:0]  ref_out;

  int n_cmp = 0;
  int n_bad = 0;
  int hand [S];
  int lfsr = 32'h1d2c3b4a;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clock_victim_sel #(.WAYS(W), .SETS(S)) i_clock_victim_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hit(req_hit),
    .req_high(req_high), .req_set(req_set), .req_way(req_way),
    .req_vld(req_vld), .req_prio(req_prio), .req_ref(req_ref),
    .ready(ready), .done(done), .victim_way(victim_way), .ref_out(ref_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04c11db7 : 0);
    return lfsr;
  endfunction

  // behavioural model and cycle-by-cycle comparison of one request
  task automatic run(input bit hit, input bit high, input int set, input int way,
                     input logic [W-1:0] vld, input logic [W-1:0] prio,
                     input logic [W-1:0] rf, input bit poke, input string tag);
    bit cold = 0;
    int free = -1;
    int v = 0;
    int lat = 1;
    logic [W-1:0] r = rf;
    for (int i = 0; i < W; i++) begin
      if (vld[i] && !prio[i] && !rf[i]) cold = 1;
      if (!vld[i] && free < 0) free = i;
    end
    if (hit || high) v = way;
    else if (free >= 0) v = free;
    else begin
      int h = hand[set];
      int k = 0;
      forever begin
        bit el;
        k++;
        el = !prio[h] || !cold;
        if (el && !r[h]) begin v = h; break; end
        if (el) r[h] = 1'b0;
        h = (h + 1) % W;
      end
      lat = 1 + k;
      hand[set] = (v + 1) % W;
    end
    r[v] = 1'b1;

    @(negedge clk);
    check(ready === 1'b1, {tag, " R10 ready before request"}, ready, 1);
    req_valid = 1'b1; req_hit = hit; req_high = high;
    req_set = SW'(set); req_way = IW'(way);
    req_vld = vld; req_prio = prio; req_ref = rf;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (poke && c == 1 && lat > 1) begin
        // request while busy, must be ignored (R10)
        check(ready === 1'b0, {tag, " R10 ready low while busy"}, ready, 0);
        req_valid = 1'b1; req_hit = 1'b0; req_high = 1'b1;
        req_set = SW'((set + 1) % S); req_way = IW'(W - 1);
      end
      if (c < lat) begin
        check(done === 1'b0, {tag, " R9 done early"}, done, 0);
      end else begin
        check(done === 1'b1, {tag, " R9 done on time"}, done, 1);
        check(victim_way === IW'(v), {tag, " victim"}, victim_way, v);
        check(ref_out === r, {tag, " ref_out"}, ref_out, r);
      end
    end
    @(negedge clk);
    check(done === 1'b0, {tag, " R9 single pulse"}, done, 0);
  endtask

  initial begin
    for (int i = 0; i < S; i++) hand[i] = 0;
    rst = 1'b1; req_valid = 1'b0; req_hit = 1'b0; req_high = 1'b0;
    req_set = '0; req_way = '0; req_vld = '0; req_prio = '0; req_ref = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(ready === 1'b1, "R1 ready after reset", ready, 1);
    check(done === 1'b0, "R1 done after reset", done, 0);

    run(1, 0, 0, 3, 8'hFF, 8'h00, 8'h05, 0, "R2 hit");
    run(1, 0, 0, 0, 8'hFF, 8'h00, 8'h01, 0, "R2 hit already set");
    run(0, 1, 0, 5, 8'hFF, 8'h20, 8'hFF, 0, "R3 high insert");
    run(0, 0, 0, 0, 8'hBB, 8'h00, 8'h00, 0, "R4 free way");
    run(0, 0, 0, 0, 8'hFF, 8'hF0, 8'h0B, 0, "R5 R7 R8 masked sweep");
    run(0, 0, 0, 0, 8'hFF, 8'h0F, 8'h50, 0, "R5 R8 masked from hand 3");
    run(0, 0, 1, 0, 8'hFF, 8'h03, 8'hFF, 1, "R6 R9 R10 full revisit");
    run(0, 0, 2, 0, 8'hFF, 8'h30, 8'hEF, 1, "R6 cold high victim");
    run(0, 0, 2, 0, 8'hFF, 8'h00, 8'h00, 0, "R8 R10 hand of set 2");
    run(0, 0, 3, 0, 8'hFF, 8'h00, 8'h7F, 0, "R8 reach last way");
    run(0, 0, 3, 0, 8'hFF, 8'h00, 8'hFE, 0, "R8 hand wrapped");
    run(0, 0, 1, 0, 8'hFF, 8'hFF, 8'h00, 0, "R1 R8 set 1 hand");

    for (int n = 0; n < 60; n++) begin
      int t = rnd();
      logic [W-1:0] vv = ((t & 7) == 0) ? W'(rnd()) : '1;
      run(t[4] & t[5], t[6] & ~(t[4] & t[5]), (t >> 8) % S, (t >> 12) % W,
          vv, W'(rnd()), W'(rnd()), t[20], "R7 mixed");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule